// File: doc/BRIEF.md
# Banked Configuration Register File with Atomic Wide-Parameter Update

This block is the register back end behind a byte-wide serial control port. The port's bit-level logic is outside the block. It hands over one strobe per event: transaction start, transaction stop, a written byte, or a byte request. The first byte written after a start loads an internal address pointer. Software cannot read this pointer back. Each later data byte, whether written or read, goes to the pointed register, and the pointer then steps by one. This continues until a stop.

The low part of the address space is a common bank. The upper part is served by one of two banks, picked by a select bit that lives inside the common bank. One parameter is wider than a byte, so it spans two neighbouring registers. Bytes written to it first land in a shadow. The live value, which drives the parameter output, changes in a single step when the final byte arrives in an unbroken, ascending sequence.

The transfer state machine has three states. `ST_IDLE` is the state outside any transaction. `ST_PTR` waits for the pointer byte. `ST_DATA` moves register bytes. The transitions are:
- *start* goes from any state to `ST_PTR`.
- *stop* goes from any state to `ST_IDLE`.
- *pointer load* (a write in `ST_PTR`) goes to `ST_DATA`.
- *current-address read* (a read in `ST_PTR`) goes to `ST_DATA`.
- *byte transfer* (a write or read in `ST_DATA`) stays in `ST_DATA`.

The shadow stage has two states. `SH_EMPTY` becomes `SH_HELD` on a write to the upper byte. `SH_HELD` returns to `SH_EMPTY` on a commit, on any other access, or on a stop.

Top module: `cfg_regbank`

## Requirements
- R1: After reset, the wide parameter equals its default (11'h2A5), the map select is 0, and every plain register reads 0x00.
- R2: The first byte written after a start loads the pointer and changes no register. A read in that state returns the byte at the current pointer.
- R3: After each data byte written or read, the pointer steps by one, wrapping from 0xFF to 0x00. Outside a transaction (after stop, before start), byte strobes have no effect.
- R4: Addresses 0x00 to 0x3F reach the same storage whatever the map select is.
- R5: Bit 5 of register 0x0E is the map select, also driven on `map_sel_o`. When it is 0, addresses 0x40 to 0xFF reach the normal bank. When it is 1, addresses 0x40 to 0x9C reach a separate sub bank.
- R6: The 11-bit parameter has bits [10:8] in bits [2:0] of register 0x34 and bits [7:0] in register 0x35. `param_o` changes only one cycle after a write to 0x35 that immediately follows a write to 0x34. It then takes both staged bytes together.
- R7: The shadow is discarded, and `param_o` keeps its value, if any of the following comes between the 0x34 and 0x35 writes: a stop, a read, or a write to another address. A write to 0x35 with no staged 0x34 byte also leaves the value unchanged.
- R8: Reads of 0x34 and 0x35 return the committed value, never the staged byte. The unused bits [7:3] of 0x34 read as 0.
- R9: With the sub bank selected, addresses 0x9D to 0xFF read 0x00, and writes there change no bank.
- R10: Read data appears on `rd_data_o` one cycle after the read strobe. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start strobe |
| stop_i | input | 1 | Transaction stop strobe |
| wr_i | input | 1 | Written-byte strobe |
| rd_i | input | 1 | Byte-request strobe |
| wr_data_i | input | 8 | Written byte |
| rd_data_o | output | 8 | Last byte read |
| map_sel_o | output | 1 | Current upper-bank select |
| param_o | output | 11 | Live wide parameter |

## Verification
Random transactions mix pointer loads into each region with runs of writes and reads, and toggle the select bit along the way. These runs tell apart the common, normal and sub banks, and show that the common bank stays the same in both maps. Directed sequences cover the following cases:
- The clean 0x34-then-0x35 update.
- Sequences broken by a stop, by a read, and by writing the bytes in the wrong order. These separate a correct commit from a partial or stale one.
- A read of the parameter while its shadow is staged.
- Writes into the unmapped sub range.
- Pointer wrap from 0xFF to 0x00.
- Byte strobes outside a transaction.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PTR,
        ST_DATA
    } xfer_state_t;

    typedef enum logic [1:0] {
        RG_COMMON,
        RG_NORMAL,
        RG_SUB,
        RG_VOID
    } region_t;

    typedef enum logic {
        SH_EMPTY,
        SH_HELD
    } shadow_state_t;

endpackage

// File: rtl/cfg_xfer_fsm.sv
module cfg_xfer_fsm
    import cfg_regbank_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          acc_wr_o,
    output logic          acc_rd_o,
    output logic [AW-1:0] acc_addr_o,
    output logic [DW-1:0] acc_data_o
);

    xfer_state_t   state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;

    // next state and pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (stop_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_PTR;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_PTR: begin
                    if (wr_i) begin
                        ptr_d   = AW'(wr_data_i);
                        state_d = ST_DATA;
                    end else if (rd_i) begin
                        ptr_d   = ptr_q + 1'b1;
                        state_d = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (wr_i || rd_i) begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // access outputs
    always_comb begin
        acc_wr_o   = 1'b0;
        acc_rd_o   = 1'b0;
        acc_addr_o = ptr_q;
        acc_data_o = wr_data_i;
        if (!stop_i && !start_i) begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_PTR: acc_rd_o = rd_i && !wr_i;
                ST_DATA: begin
                    acc_wr_o = wr_i;
                    acc_rd_o = rd_i && !wr_i;
                end
                default: begin
                end
            endcase
        end
    end

    p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR && wr_i && !start_i && !stop_i) |=> (ptr_q == $past(AW'(wr_data_i))));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && (wr_i || rd_i) && !start_i && !stop_i) |=> (ptr_q == $past(ptr_q) + 1'b1));

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!acc_wr_o && !acc_rd_o));

    p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/cfg_bank_store.sv
module cfg_bank_store
    import cfg_regbank_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] SPLIT    = 8'h40,
    parameter logic [AW-1:0] SUB_LAST = 8'h9C,
    parameter logic [AW-1:0] SEL_ADDR = 8'h0E,
    parameter int            SEL_BIT  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] rd_byte_o,
    output logic          sub_sel_o,
    output region_t       region_o
);

    localparam int COMMON_N = int'(SPLIT);
    localparam int NORMAL_N = (2 ** AW) - COMMON_N;
    localparam int SUB_N    = int'(SUB_LAST) - COMMON_N + 1;
    localparam int CW       = $clog2(COMMON_N);
    localparam int NW       = $clog2(NORMAL_N);
    localparam int SW       = $clog2(SUB_N);

    logic [DW-1:0] common_q [COMMON_N];
    logic [DW-1:0] normal_q [NORMAL_N];
    logic [DW-1:0] sub_q    [SUB_N];

    logic [AW-1:0] off;
    logic [CW-1:0] cidx;
    logic [NW-1:0] nidx;
    logic [SW-1:0] sidx;

    assign off       = addr_i - SPLIT;
    assign cidx      = addr_i[CW-1:0];
    assign nidx      = off[NW-1:0];
    assign sidx      = off[SW-1:0];
    assign sub_sel_o = common_q[SEL_ADDR[CW-1:0]][SEL_BIT];

    // region decode
    always_comb begin
        if (addr_i < SPLIT) begin
            region_o = RG_COMMON;
        end else if (!sub_sel_o) begin
            region_o = RG_NORMAL;
        end else if (addr_i <= SUB_LAST) begin
            region_o = RG_SUB;
        end else begin
            region_o = RG_VOID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < COMMON_N; i++) common_q[i] <= '0;
            for (int i = 0; i < NORMAL_N; i++) normal_q[i] <= '0;
            for (int i = 0; i < SUB_N; i++)    sub_q[i]    <= '0;
        end else if (wr_en_i) begin
            unique case (region_o)
                RG_COMMON: common_q[cidx] <= data_i;
                RG_NORMAL: normal_q[nidx] <= data_i;
                RG_SUB:    sub_q[sidx]    <= data_i;
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        unique case (region_o)
            RG_COMMON: rd_byte_o = common_q[cidx];
            RG_NORMAL: rd_byte_o = normal_q[nidx];
            RG_SUB:    rd_byte_o = sub_q[sidx];
            default:   rd_byte_o = '0;
        endcase
    end

    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == SEL_ADDR) |=> $stable(sub_sel_o));

endmodule

// File: rtl/cfg_param_stage.sv
module cfg_param_stage
    import cfg_regbank_pkg::*;
#(
    parameter int            AW      = 8,
    parameter int            DW      = 8,
    parameter int            PW      = 11,
    parameter logic [AW-1:0] HI_ADDR = 8'h34,
    parameter logic [PW-1:0] DEFAULT = 11'h2A5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_wr_i,
    input  logic          acc_rd_i,
    input  logic          stop_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          hit_o,
    output logic [DW-1:0] rd_byte_o,
    output logic [PW-1:0] live_o
);

    localparam logic [AW-1:0] LO_ADDR = HI_ADDR + 1'b1;

    shadow_state_t sh_q, sh_d;
    logic [DW-1:0] shadow_q;
    logic [PW-1:0] live_q;
    logic          commit;
    logic          stage_hi;

    assign hit_o    = (addr_i == HI_ADDR) || (addr_i == LO_ADDR);
    assign stage_hi = acc_wr_i && (addr_i == HI_ADDR);
    assign live_o   = live_q;

    // shadow next state
    always_comb begin
        sh_d   = sh_q;
        commit = 1'b0;
        if (stop_i) begin
            sh_d = SH_EMPTY;
        end else begin
            unique case (sh_q)
                SH_EMPTY: begin
                    if (stage_hi) sh_d = SH_HELD;
                end
                SH_HELD: begin
                    if (stage_hi) begin
                        sh_d = SH_HELD;
                    end else if (acc_wr_i || acc_rd_i) begin
                        sh_d   = SH_EMPTY;
                        commit = acc_wr_i && (addr_i == LO_ADDR);
                    end
                end
                default: sh_d = SH_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= SH_EMPTY;
            shadow_q <= '0;
            live_q   <= DEFAULT;
        end else begin
            sh_q <= sh_d;
            if (stage_hi) shadow_q <= data_i;
            if (commit)   live_q   <= PW'({shadow_q, data_i});
        end
    end

    always_comb begin
        if (addr_i == HI_ADDR) rd_byte_o = DW'(live_q >> DW);
        else                   rd_byte_o = live_q[DW-1:0];
    end

    p_live_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr_i && addr_i == LO_ADDR) |=> $stable(live_o));

    p_lone_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_i && addr_i == LO_ADDR && sh_q == SH_EMPTY) |=> $stable(live_o));

    p_stop_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (sh_q == SH_EMPTY));

    p_read_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd_i && !stop_i) |=> (sh_q == SH_EMPTY));

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter int            PW        = 11,
    parameter logic [AW-1:0] SPLIT     = 8'h40,
    parameter logic [AW-1:0] SUB_LAST  = 8'h9C,
    parameter logic [AW-1:0] SEL_ADDR  = 8'h0E,
    parameter int            SEL_BIT   = 5,
    parameter logic [AW-1:0] PAR_HI    = 8'h34,
    parameter logic [PW-1:0] PAR_RESET = 11'h2A5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          map_sel_o,
    output logic [PW-1:0] param_o
);

    logic          acc_wr, acc_rd;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_data;
    logic          par_hit;
    logic [DW-1:0] par_byte, bank_byte;
    region_t       region;
    logic [DW-1:0] rd_data_q;

    cfg_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .wr_data_i  (wr_data_i),
        .acc_wr_o   (acc_wr),
        .acc_rd_o   (acc_rd),
        .acc_addr_o (acc_addr),
        .acc_data_o (acc_data)
    );

    cfg_bank_store #(
        .AW(AW), .DW(DW), .SPLIT(SPLIT), .SUB_LAST(SUB_LAST),
        .SEL_ADDR(SEL_ADDR), .SEL_BIT(SEL_BIT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (acc_wr && !par_hit),
        .addr_i    (acc_addr),
        .data_i    (acc_data),
        .rd_byte_o (bank_byte),
        .sub_sel_o (map_sel_o),
        .region_o  (region)
    );

    cfg_param_stage #(
        .AW(AW), .DW(DW), .PW(PW), .HI_ADDR(PAR_HI), .DEFAULT(PAR_RESET)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_wr_i  (acc_wr),
        .acc_rd_i  (acc_rd),
        .stop_i    (stop_i),
        .addr_i    (acc_addr),
        .data_i    (acc_data),
        .hit_o     (par_hit),
        .rd_byte_o (par_byte),
        .live_o    (param_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (acc_rd) begin
            rd_data_q <= par_hit ? par_byte : bank_byte;
        end
    end

    assign rd_data_o = rd_data_q;

    p_void_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && region == RG_VOID) |=> (rd_data_o == '0));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(rd_data_o));

endmodule

// File: tb/cfg_regbank_bench.sv
module cfg_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, stop_i, wr_i, rd_i;
    logic [7:0]  wr_data_i;
    logic [7:0]  rd_data_o;
    logic        map_sel_o;
    logic [10:0] param_o;

    always #10 clk = ~clk;

    cfg_regbank u_cfg_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .wr_i      (wr_i),
        .rd_i      (rd_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .map_sel_o (map_sel_o),
        .param_o   (param_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model
    logic [7:0]  m_comm [64];
    logic [7:0]  m_norm [192];
    logic [7:0]  m_sub  [93];
    logic [10:0] m_param;
    logic [7:0]  m_shadow;
    bit          m_pend;
    int          m_st;
    logic [7:0]  m_ptr;
    logic [7:0]  m_last;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_sel();
        return m_comm[14][5];
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'h34) return {5'b0, m_param[10:8]};
        if (a == 8'h35) return m_param[7:0];
        if (a < 8'h40)  return m_comm[a[5:0]];
        if (!m_sel())   return m_norm[a - 8'h40];
        if (a <= 8'h9C) return m_sub[a - 8'h40];
        return 8'h00;
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h35 && m_pend) m_param = {m_shadow[2:0], d};
        if (a == 8'h34) begin
            m_shadow = d;
            m_pend   = 1'b1;
        end else begin
            m_pend = 1'b0;
        end
        if (a != 8'h34 && a != 8'h35) begin
            if (a < 8'h40)       m_comm[a[5:0]] = d;
            else if (!m_sel())   m_norm[a - 8'h40] = d;
            else if (a <= 8'h9C) m_sub[a - 8'h40] = d;
        end
    endtask

    task automatic drive(input bit s, input bit p, input bit w, input bit r, input logic [7:0] d);
        @(negedge clk);
        start_i = s; stop_i = p; wr_i = w; rd_i = r; wr_data_i = d;
        @(negedge clk);
        start_i = 0; stop_i = 0; wr_i = 0; rd_i = 0; wr_data_i = 8'h00;
    endtask

    task automatic post_checks();
        chk("R6 param", 32'(param_o), 32'(m_param));
        chk("R5 map_sel", 32'(map_sel_o), 32'(m_sel()));
    endtask

    task automatic op_start();
        drive(1, 0, 0, 0, 8'h00);
        m_st = 1;
        post_checks();
    endtask

    task automatic op_stop();
        drive(0, 1, 0, 0, 8'h00);
        m_st   = 0;
        m_pend = 0;
        post_checks();
    endtask

    task automatic op_wr(input logic [7:0] d);
        drive(0, 0, 1, 0, d);
        if (m_st == 1) begin
            m_ptr = d;
            m_st  = 2;
        end else if (m_st == 2) begin
            m_write(m_ptr, d);
            m_ptr = m_ptr + 8'd1;
        end
        post_checks();
    endtask

    task automatic op_rd(input string tag);
        drive(0, 0, 0, 1, 8'h00);
        if (m_st != 0) begin
            m_last = m_read(m_ptr);
            m_pend = 0;
            m_ptr  = m_ptr + 8'd1;
            m_st   = 2;
        end
        chk(tag, 32'(rd_data_o), 32'(m_last));
        post_checks();
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        op_start(); op_wr(a); op_wr(d); op_stop();
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        op_start(); op_wr(a); op_rd(tag); op_stop();
    endtask

    function automatic logic [7:0] pick_addr();
        unique case ($urandom % 7)
            0: return 8'h34;
            1: return 8'h0E;
            2: return 8'(8'h30 + $urandom % 8);
            3: return 8'($urandom % 64);
            4: return 8'(8'h40 + $urandom % 192);
            5: return 8'(8'h98 + $urandom % 10);
            default: return 8'(8'hFC + $urandom % 4);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd7321);
        rst_n = 0; start_i = 0; stop_i = 0; wr_i = 0; rd_i = 0; wr_data_i = 0;
        for (int i = 0; i < 64; i++)  m_comm[i] = 8'h00;
        for (int i = 0; i < 192; i++) m_norm[i] = 8'h00;
        for (int i = 0; i < 93; i++)  m_sub[i]  = 8'h00;
        m_param = 11'h2A5; m_shadow = 8'h00; m_pend = 0; m_st = 0; m_ptr = 8'h00; m_last = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 param default", 32'(param_o), 32'h2A5);
        chk("R1 map_sel", 32'(map_sel_o), 32'h0);
        chk("R1 rd_data", 32'(rd_data_o), 32'h0);
        rd_reg(8'h0E, "R1 reg 0x0E");
        rd_reg(8'h34, "R1 param hi byte");
        chk("R1 hi byte value", 32'(rd_data_o), 32'h02);
        rd_reg(8'h80, "R1 normal reg");

        // R2 pointer byte stores nothing; read in pointer state uses current pointer
        wr_reg(8'h10, 8'h5A);
        op_start(); op_wr(8'h11); op_stop();
        rd_reg(8'h11, "R2 pointer byte not stored");
        op_start(); op_wr(8'h10); op_start(); op_rd("R2 current-address read");
        chk("R2 read value", 32'(rd_data_o), 32'h5A);
        op_stop();

        // R6 clean update
        op_start(); op_wr(8'h34); op_wr(8'h05);
        chk("R6 unchanged while staged", 32'(param_o), 32'h2A5);
        op_wr(8'h3C); op_stop();
        chk("R6 committed", 32'(param_o), 32'h53C);

        // R7 broken by stop
        op_start(); op_wr(8'h34); op_wr(8'h01); op_stop();
        op_start(); op_wr(8'h35); op_wr(8'h77); op_stop();
        chk("R7 stop breaks", 32'(param_o), 32'h53C);
        // R7/R8 broken by read; read returns live value
        op_start(); op_wr(8'h34); op_wr(8'h06); op_rd("R8 read during stage");
        chk("R8 live low byte", 32'(rd_data_o), 32'h3C);
        op_stop();
        op_start(); op_wr(8'h35); op_wr(8'h11); op_stop();
        chk("R7 read breaks", 32'(param_o), 32'h53C);
        // R7 wrong order
        op_start(); op_wr(8'h33); op_wr(8'h44); op_wr(8'h07); op_stop();
        op_start(); op_wr(8'h35); op_wr(8'h99); op_wr(8'h00); op_stop();
        chk("R7 wrong order", 32'(param_o), 32'h53C);
        rd_reg(8'h34, "R8 hi readback");
        chk("R8 hi bits", 32'(rd_data_o), 32'h05);

        // R4/R5 banks
        wr_reg(8'h20, 8'hAA);
        wr_reg(8'h50, 8'h11);
        wr_reg(8'h0E, 8'h20);
        chk("R5 select set", 32'(map_sel_o), 32'h1);
        rd_reg(8'h20, "R4 common in sub map");
        chk("R4 common value", 32'(rd_data_o), 32'hAA);
        rd_reg(8'h50, "R5 sub bank separate");
        chk("R5 sub value", 32'(rd_data_o), 32'h00);
        wr_reg(8'h50, 8'h22);
        // R9 void region
        wr_reg(8'hA0, 8'h33);
        rd_reg(8'hA0, "R9 void reads zero");
        chk("R9 void value", 32'(rd_data_o), 32'h00);
        wr_reg(8'h0E, 8'h00);
        rd_reg(8'h50, "R5 normal kept");
        chk("R5 normal value", 32'(rd_data_o), 32'h11);
        rd_reg(8'hA0, "R9 normal untouched");
        chk("R9 normal value", 32'(rd_data_o), 32'h00);

        // R3 wrap and idle strobes
        op_start(); op_wr(8'hFE); op_wr(8'h01); op_wr(8'h02); op_wr(8'h03); op_stop();
        rd_reg(8'h00, "R3 wrap to 0x00");
        chk("R3 wrap value", 32'(rd_data_o), 32'h03);
        op_wr(8'h01); op_wr(8'h77);
        rd_reg(8'h01, "R3 idle write ignored");
        chk("R3 idle value", 32'(rd_data_o), 32'h00);

        // R10 hold
        rd_reg(8'hFE, "R10 read");
        drive(0, 0, 0, 0, 8'h00); drive(0, 0, 0, 0, 8'h00);
        chk("R10 hold", 32'(rd_data_o), 32'h01);

        // random transactions
        for (int t = 0; t < 600; t++) begin
            int n;
            op_start();
            op_wr(pick_addr());
            n = 1 + int'($urandom % 5);
            for (int k = 0; k < n; k++) begin
                if ($urandom % 2) op_wr(8'($urandom));
                else              op_rd("R3 random read");
            end
            if ($urandom % 4 != 0) op_stop();
        end
        op_stop();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule